// File: doc/BRIEF.md
# Storage Command Client Sequencer

This block is the user-side controller for one port of a storage core's crossbar. A local agent hands it a request: write, read or identify, with a start sector and a sector count. The sequencer frames the command as a packet on the port's command stream. For a write, the data beats come from a local write-data stream. It then takes in the response packets, passes read data to a local output, and reports completion along with an error flag.

A write command carries `count * WORDS_PER_SECTOR` data beats. A count of zero still sends one beat. Read and identify commands go out as one beat with both packet markers set. A transaction ends on the closing beat of the response packet that is flagged last. For a read, that packet is an empty one that follows the data packets. The error flag covers two cases: the core reported a fault on any response beat, or the type flags on a response did not match the issued command.

Top module: `stor_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_stb`, `rsp_ack`, `rd_valid` and `done` are 0.
- R2: A request is taken only while `req_ready` is 1, which holds only between transactions. A request presented during a transaction issues no command. Op encoding: 1 = write, 2 = read, 3 = identify.
- R3: Each command beat has exactly one of `cmd_write`, `cmd_read`, `cmd_identify` set. The flags, `cmd_sector` and `cmd_count` stay unchanged across all beats of a packet.
- R4: An identify command is one beat with `cmd_sop` = `cmd_eop` = 1, with `cmd_sector`, `cmd_count` and `cmd_data` all zero.
- R5: A read command is one beat with `cmd_sop` = `cmd_eop` = 1, the requested sector and count, and `cmd_data` zero.
- R6: A write command has `count * WORDS_PER_SECTOR` beats, or one beat if the count is 0. `cmd_sop` is set on the first beat and `cmd_eop` on the last. `cmd_stb` follows `wr_valid`, `cmd_data` carries `wr_data`, and `wr_ready` is 1 only on an accepted beat.
- R7: For a read, each response beat with `rsp_read` = 1 and `rsp_last` = 0 appears on `rd_data` with `rd_valid` = 1, and `rsp_ack` follows `rd_ready` for such beats.
- R8: The accepted beat with `rsp_last` = 1 and `rsp_eop` = 1 ends the transaction. It is not forwarded. `done` is 1 for exactly the next cycle, and `req_ready` returns the cycle after that.
- R9: Response data of write and identify commands is discarded: `rd_valid` stays 0 and the beats are acknowledged.
- R10: If any accepted response beat of a transaction has `rsp_failed` = 1, `err` is 1 while `done` is 1. The flag is cleared for the next transaction.
- R11: If an accepted response beat has type flags that differ from the issued command, `err` is 1 while `done` is 1.
- R12: `rsp_ack` is 0 while the command is still being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 2 | 1 write, 2 read, 3 identify |
| req_sector | input | 48 | Start sector |
| req_count | input | 16 | Sector count |
| wr_valid | input | 1 | Write data present |
| wr_ready | output | 1 | Write data consumed |
| wr_data | input | 32 | Write data beat |
| cmd_stb | output | 1 | Command beat valid |
| cmd_ack | input | 1 | Core accepts command beat |
| cmd_sop | output | 1 | First beat of command packet |
| cmd_eop | output | 1 | Last beat of command packet |
| cmd_write | output | 1 | Write command |
| cmd_read | output | 1 | Read command |
| cmd_identify | output | 1 | Identify command |
| cmd_sector | output | 48 | Command sector |
| cmd_count | output | 16 | Command count |
| cmd_data | output | 32 | Command write data |
| rsp_stb | input | 1 | Response beat valid |
| rsp_ack | output | 1 | Response beat accepted |
| rsp_eop | input | 1 | Last beat of response packet |
| rsp_write | input | 1 | Response belongs to a write |
| rsp_read | input | 1 | Response belongs to a read |
| rsp_identify | input | 1 | Response belongs to an identify |
| rsp_last | input | 1 | Final response packet |
| rsp_failed | input | 1 | Core detected an error |
| rsp_data | input | 32 | Response data |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Local sink takes read data |
| rd_data | output | 32 | Read data |
| done | output | 1 | Transaction complete (one cycle) |
| err | output | 1 | Error status, valid with done |

## Verification
The assertions assume that the core keeps a response beat steady until it is acknowledged. They also assume that a final packet ends on a beat carrying both `rsp_last` and `rsp_eop`. The bench drives each response beat at a falling edge and holds it until `rsp_ack` is seen. It ends every response with such a final beat and sends a request only with a nonzero op. The write-data source may pause, and the bench inserts gaps to exercise this.

// File: rtl/stor_seq_pkg.sv
package stor_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_IDENT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } st_e;

  // type flags ordered {write, read, identify}
  function automatic logic [2:0] op_flags(op_e op);
    logic [2:0] f;
    unique case (op)
      OP_WRITE: f = 3'b100;
      OP_READ:  f = 3'b010;
      OP_IDENT: f = 3'b001;
      default:  f = 3'b000;
    endcase
    return f;
  endfunction

  // number of beats in the command packet
  function automatic logic [31:0] cmd_beats(op_e op, logic [31:0] count,
                                            logic [31:0] wps);
    if (op != OP_WRITE || count == 32'd0) return 32'd1;
    return count * wps;
  endfunction

endpackage

// File: rtl/stor_cmd_tx.sv
module stor_cmd_tx
  import stor_seq_pkg::*;
#(
  parameter int DATA_W           = 32,
  parameter int SECTOR_W         = 48,
  parameter int COUNT_W          = 16,
  parameter int WORDS_PER_SECTOR = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                active,
  input  op_e                 op,
  input  logic [SECTOR_W-1:0] sector,
  input  logic [COUNT_W-1:0]  count,
  input  logic                wr_valid,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_ready,
  output logic                cmd_stb,
  input  logic                cmd_ack,
  output logic                cmd_sop,
  output logic                cmd_eop,
  output logic                cmd_write,
  output logic                cmd_read,
  output logic                cmd_identify,
  output logic [SECTOR_W-1:0] cmd_sector,
  output logic [COUNT_W-1:0]  cmd_count,
  output logic [DATA_W-1:0]   cmd_data,
  output logic                tx_done
);

  localparam int BW = COUNT_W + $clog2(WORDS_PER_SECTOR) + 1;

  logic [BW-1:0] idx;
  logic [BW-1:0] total;
  logic          is_wr;
  logic          beat_acc;

  assign total = BW'(cmd_beats(op, 32'(count), 32'(WORDS_PER_SECTOR)));
  assign is_wr = (op == OP_WRITE);

  assign {cmd_write, cmd_read, cmd_identify} = active ? op_flags(op) : 3'b000;
  assign cmd_sector = sector;
  assign cmd_count  = count;
  assign cmd_stb    = active && (is_wr ? wr_valid : 1'b1);
  assign cmd_data   = is_wr ? wr_data : '0;
  assign cmd_sop    = (idx == '0);
  assign cmd_eop    = (idx == total - BW'(1));
  assign beat_acc   = cmd_stb && cmd_ack;
  assign wr_ready   = beat_acc && is_wr;
  assign tx_done    = beat_acc && cmd_eop;

  always_ff @(posedge clk) begin
    if (!rst_n || start) idx <= '0;
    else if (beat_acc && !cmd_eop) idx <= idx + BW'(1);
  end

  assert_one_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $onehot({cmd_write, cmd_read, cmd_identify}));

  assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && !cmd_eop) |=>
      $stable({cmd_write, cmd_read, cmd_identify, cmd_sector, cmd_count}));

  assert_ident_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_identify) |->
      (cmd_sector == '0 && cmd_count == '0 && cmd_sop && cmd_eop && cmd_data == '0));

  assert_read_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_read) |-> (cmd_sop && cmd_eop));

  assert_wr_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (cmd_stb && cmd_ack && cmd_write));

endmodule

// File: rtl/stor_rsp_rx.sv
module stor_rsp_rx
  import stor_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  op_e               op,
  input  logic              rsp_stb,
  output logic              rsp_ack,
  input  logic              rsp_eop,
  input  logic              rsp_write,
  input  logic              rsp_read,
  input  logic              rsp_identify,
  input  logic              rsp_last,
  input  logic              rsp_failed,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_end,
  output logic              err_q
);

  logic fwd;
  logic acc;
  logic type_bad;
  logic fail_seen;

  assign fwd       = (op == OP_READ) && rsp_read && !rsp_last;
  assign rsp_ack   = active && (fwd ? rd_ready : 1'b1);
  assign rd_valid  = active && rsp_stb && fwd;
  assign rd_data   = rsp_data;
  assign acc       = rsp_stb && rsp_ack;
  assign type_bad  = acc && ({rsp_write, rsp_read, rsp_identify} != op_flags(op));
  assign fail_seen = acc && rsp_failed;
  assign rx_end    = acc && rsp_last && rsp_eop;

  always_ff @(posedge clk) begin
    if (!rst_n || start) err_q <= 1'b0;
    else if (type_bad || fail_seen) err_q <= 1'b1;
  end

  assert_fwd_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rsp_read && !rsp_last && !rsp_write && !rsp_identify));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !rsp_ack);

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_seen && !start) |=> err_q);

  assert_mismatch_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (type_bad && !start) |=> err_q);

endmodule

// File: rtl/stor_cmd_seq.sv
module stor_cmd_seq
  import stor_seq_pkg::*;
#(
  parameter int DATA_W           = 32,
  parameter int SECTOR_W         = 48,
  parameter int COUNT_W          = 16,
  parameter int WORDS_PER_SECTOR = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [SECTOR_W-1:0] req_sector,
  input  logic [COUNT_W-1:0]  req_count,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                cmd_stb,
  input  logic                cmd_ack,
  output logic                cmd_sop,
  output logic                cmd_eop,
  output logic                cmd_write,
  output logic                cmd_read,
  output logic                cmd_identify,
  output logic [SECTOR_W-1:0] cmd_sector,
  output logic [COUNT_W-1:0]  cmd_count,
  output logic [DATA_W-1:0]   cmd_data,
  input  logic                rsp_stb,
  output logic                rsp_ack,
  input  logic                rsp_eop,
  input  logic                rsp_write,
  input  logic                rsp_read,
  input  logic                rsp_identify,
  input  logic                rsp_last,
  input  logic                rsp_failed,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic                err
);

  st_e                 st;
  op_e                 op_q;
  logic [SECTOR_W-1:0] sector_q;
  logic [COUNT_W-1:0]  count_q;
  logic                start;
  logic                tx_done;
  logic                rx_end;
  logic                err_q;
  logic                in_send;
  logic                in_wait;

  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready && (req_op != 2'd0);
  assign in_send   = (st == ST_SEND);
  assign in_wait   = (st == ST_WAIT);
  assign done      = (st == ST_DONE);
  assign err       = done && err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= OP_NONE;
      sector_q <= '0;
      count_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st       <= ST_SEND;
          op_q     <= op_e'(req_op);
          sector_q <= (op_e'(req_op) == OP_IDENT) ? '0 : req_sector;
          count_q  <= (op_e'(req_op) == OP_IDENT) ? '0 : req_count;
        end
        ST_SEND: if (tx_done) st <= ST_WAIT;
        ST_WAIT: if (rx_end) st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  stor_cmd_tx #(
    .DATA_W(DATA_W), .SECTOR_W(SECTOR_W), .COUNT_W(COUNT_W),
    .WORDS_PER_SECTOR(WORDS_PER_SECTOR)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .active(in_send), .op(op_q),
    .sector(sector_q), .count(count_q),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .cmd_stb(cmd_stb), .cmd_ack(cmd_ack), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_identify(cmd_identify),
    .cmd_sector(cmd_sector), .cmd_count(cmd_count), .cmd_data(cmd_data),
    .tx_done(tx_done)
  );

  stor_rsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .active(in_wait), .op(op_q),
    .rsp_stb(rsp_stb), .rsp_ack(rsp_ack), .rsp_eop(rsp_eop),
    .rsp_write(rsp_write), .rsp_read(rsp_read), .rsp_identify(rsp_identify),
    .rsp_last(rsp_last), .rsp_failed(rsp_failed), .rsp_data(rsp_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rx_end(rx_end), .err_q(err_q)
  );

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_end_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> done);

  assert_no_early_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> !rsp_ack);

endmodule

// File: tb/sim_stor_cmd_seq.sv
module sim_stor_cmd_seq;

  localparam int WPS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, wr_valid = 0, cmd_ack = 0, rd_ready = 0;
  logic [1:0]  req_op = 0;
  logic [47:0] req_sector = 0;
  logic [15:0] req_count = 0;
  logic [31:0] wr_data = 0, rsp_data = 0;
  logic        rsp_stb = 0, rsp_eop = 0, rsp_write = 0, rsp_read = 0;
  logic        rsp_identify = 0, rsp_last = 0, rsp_failed = 0;
  logic        req_ready, wr_ready, cmd_stb, cmd_sop, cmd_eop;
  logic        cmd_write, cmd_read, cmd_identify, rsp_ack, rd_valid, done, err;
  logic [47:0] cmd_sector;
  logic [15:0] cmd_count;
  logic [31:0] cmd_data, rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  stor_cmd_seq #(.WORDS_PER_SECTOR(WPS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sector(req_sector), .req_count(req_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cmd_stb(cmd_stb), .cmd_ack(cmd_ack), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_identify(cmd_identify),
    .cmd_sector(cmd_sector), .cmd_count(cmd_count), .cmd_data(cmd_data),
    .rsp_stb(rsp_stb), .rsp_ack(rsp_ack), .rsp_eop(rsp_eop),
    .rsp_write(rsp_write), .rsp_read(rsp_read), .rsp_identify(rsp_identify),
    .rsp_last(rsp_last), .rsp_failed(rsp_failed), .rsp_data(rsp_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [47:0] sec,
                        input logic [15:0] cnt);
    @(negedge clk);
    req_valid = 1; req_op = op; req_sector = sec; req_count = cnt;
    #1 chk(req_ready == 1, "R2 idle ready", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic rsp_beat(input logic [2:0] wri, input bit eop, input bit last,
                          input bit fail, input logic [31:0] d, input bit exp_fwd);
    @(negedge clk);
    {rsp_write, rsp_read, rsp_identify} = wri;
    rsp_stb = 1; rsp_eop = eop; rsp_last = last; rsp_failed = fail; rsp_data = d;
    #1;
    while (!rsp_ack) begin @(negedge clk); #1; end
    chk(rd_valid == exp_fwd, exp_fwd ? "R7 forward" : "R9 discard", rd_valid, exp_fwd);
    if (exp_fwd) chk(rd_data == d, "R7 read data", rd_data, d);
    @(posedge clk);
    #1 rsp_stb = 0; rsp_failed = 0;
  endtask

  task automatic expect_done(input bit exp_err, input string req);
    @(negedge clk); #1;
    chk(done == 1, "R8 done", done, 1);
    chk(err == exp_err, req, err, exp_err);
    @(negedge clk); #1;
    chk(done == 0, "R8 done one cycle", done, 0);
    chk(req_ready == 1, "R8 ready again", req_ready, 1);
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(cmd_stb == 0, "R1 cmd_stb", cmd_stb, 0);
    chk(rsp_ack == 0, "R1 rsp_ack", rsp_ack, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(done == 0, "R1 done", done, 0);
  endtask

  task automatic t_identify;
    do_req(2'd3, 48'h123, 16'd5);
    @(negedge clk);
    cmd_ack = 0; req_valid = 1; req_op = 2'd2;
    #1;
    chk(req_ready == 0, "R2 busy", req_ready, 0);
    chk(cmd_stb && cmd_identify && !cmd_read && !cmd_write, "R4 ident flags",
        {cmd_stb, cmd_write, cmd_read, cmd_identify}, 4'b1001);
    chk(cmd_sector == 0 && cmd_count == 0, "R4 zero fields", {cmd_sector, cmd_count}, 0);
    chk(cmd_sop && cmd_eop && cmd_data == 0, "R4 single beat", {cmd_sop, cmd_eop}, 2'b11);
    @(negedge clk);
    req_valid = 0; cmd_ack = 1;
    #1 chk(cmd_identify == 1 && cmd_read == 0, "R2 request ignored", cmd_read, 0);
    @(posedge clk);
    #1 cmd_ack = 0;
    @(negedge clk); #1;
    chk(cmd_stb == 0, "R4 one beat only", cmd_stb, 0);
    rsp_beat(3'b001, 0, 0, 0, 32'hAAAA0001, 0);
    rsp_beat(3'b001, 1, 1, 0, 32'hAAAA0002, 0);
    expect_done(0, "R10 no error");
  endtask

  task automatic t_read;
    do_req(2'd2, 48'hABCDEF012345, 16'd3);
    @(negedge clk);
    rsp_stb = 1; rsp_read = 1; rsp_write = 0; rsp_identify = 0; rsp_last = 0;
    #1;
    chk(rsp_ack == 0, "R12 no ack while sending", rsp_ack, 0);
    chk(cmd_stb && cmd_read && cmd_sop && cmd_eop, "R5 read beat",
        {cmd_stb, cmd_read, cmd_sop, cmd_eop}, 4'hF);
    chk(cmd_sector == 48'hABCDEF012345, "R5 sector", cmd_sector, 48'hABCDEF012345);
    chk(cmd_count == 3 && cmd_data == 0, "R5 count/data", cmd_count, 3);
    cmd_ack = 1;
    @(posedge clk);
    #1 cmd_ack = 0; rsp_stb = 0;
    // backpressure on first data beat
    @(negedge clk);
    rsp_stb = 1; rsp_eop = 0; rsp_data = 32'h11223344; rd_ready = 0;
    #1;
    chk(rd_valid == 1 && rd_data == 32'h11223344, "R7 data shown", rd_data, 32'h11223344);
    chk(rsp_ack == 0, "R7 held by rd_ready", rsp_ack, 0);
    @(negedge clk);
    rd_ready = 1;
    #1 chk(rsp_ack == 1, "R7 ack follows rd_ready", rsp_ack, 1);
    @(posedge clk);
    #1 rsp_stb = 0;
    rsp_beat(3'b010, 1, 0, 0, 32'h55667788, 1);
    rsp_beat(3'b010, 1, 1, 0, 32'hDEADBEEF, 0);
    expect_done(0, "R8 read no error");
    rd_ready = 0;
  endtask

  task automatic t_write(input logic [15:0] cnt);
    int n;
    n = (cnt == 0) ? 1 : cnt * WPS;
    do_req(2'd1, 48'h42, cnt);
    for (int b = 0; b < n; b++) begin
      if (b == 1) begin
        @(negedge clk);
        wr_valid = 0; cmd_ack = 1;
        #1 chk(cmd_stb == 0 && wr_ready == 0, "R6 gap", cmd_stb, 0);
      end
      @(negedge clk);
      wr_valid = 1; wr_data = 32'hC0DE0000 + b; cmd_ack = 1;
      #1;
      chk(cmd_stb && cmd_write && wr_ready, "R6 beat", {cmd_stb, cmd_write, wr_ready}, 3'b111);
      chk(cmd_data == 32'hC0DE0000 + b, "R6 data", cmd_data, 32'hC0DE0000 + b);
      chk(cmd_sop == (b == 0) && cmd_eop == (b == n - 1), "R6 framing",
          {cmd_sop, cmd_eop}, {b == 0, b == n - 1});
      chk(cmd_count == cnt && cmd_sector == 48'h42, "R3 fields", cmd_count, cnt);
      @(posedge clk);
    end
    #1 wr_valid = 0; cmd_ack = 0;
    @(negedge clk); #1;
    chk(cmd_stb == 0, "R6 beat total", cmd_stb, 0);
    rsp_beat(3'b100, 1, 1, 0, 32'h0BADF00D, 0);
    expect_done(0, "R9 write no error");
  endtask

  task automatic t_failed;
    do_req(2'd2, 48'h7, 16'd1);
    @(negedge clk); cmd_ack = 1;
    @(posedge clk); #1 cmd_ack = 0;
    rd_ready = 1;
    rsp_beat(3'b010, 1, 0, 1, 32'h99, 1);
    rsp_beat(3'b010, 1, 1, 0, 32'h0, 0);
    expect_done(1, "R10 failed flag");
    rd_ready = 0;
  endtask

  task automatic t_mismatch;
    do_req(2'd3, 48'h0, 16'd0);
    @(negedge clk); cmd_ack = 1;
    @(posedge clk); #1 cmd_ack = 0;
    rsp_beat(3'b010, 1, 1, 0, 32'h0, 0);
    expect_done(1, "R11 type mismatch");
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_identify;
    t_read;
    t_write(16'd2);
    t_write(16'd0);
    t_failed;
    t_identify;
    t_mismatch;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule